// File: doc/BRIEF.md
# Two-Wire Bus Master Status Flags and Clock Stretch Control

This block keeps the status flags of a two-wire (I2C) bus master and decides when the master must hold the serial clock low. The byte engine sends it single-cycle event strobes: a byte was received, a byte was sent, arbitration was lost (with a code for the kind of bit being driven), a bus error was seen, a START was asked for while the bus state was unknown, and a new acknowledge bit was sampled. Register-side strobes arrive alongside them: a write to the status register with its data, a write to the address register, a write or read of the data register, and a write to the command field.

The receive-done and send-done flags stop the clock. While either one is pending, the clock-hold output asks the bit engine to keep SCL low. Software releases the bus in one of two ways. It can write one to the flag. It can also touch the address, data or command registers, which clears both flags as a side effect. The block also builds the packed status byte, and it raises an interrupt when a pending flag has its enable input high. A set event that lands in the same cycle as a clearing access takes priority, so no event is lost.

Top module: `twm_status_ctrl`

## Requirements
- R1: The receive flag (status bit 7) sets one cycle after `ev_rx_byte` when `rx_byte_faulted` is low. A received byte with `rx_byte_faulted` high leaves it unchanged.
- R2: The send flag (status bit 6) sets one cycle after any of these: `ev_tx_byte` (whatever the fault state), `ev_arb_lost` with `arb_kind` = 1 (arbitration lost on a NACK bit), or `ev_start_unknown`.
- R3: A status write (`st_wr`) clears the flags whose data bits are one: bit 7 receive, bit 6 send, bit 3 arbitration, bit 2 bus error. Data bits that are zero leave their flags unchanged.
- R4: Any of these clears both the receive and send flags on the next cycle: `addr_wr`, `data_wr`, `data_rd`, or `cmd_wr` with a nonzero `cmd_code`. A `cmd_wr` with `cmd_code` = 0 clears nothing.
- R5: `scl_hold` and the clock-hold status bit (bit 5) are high exactly while the receive or send flag is set.
- R6: The acknowledge bit (bit 4) loads `rx_ack_bit` (0 = ACK, 1 = NACK) in the cycle after `rx_ack_valid`. At any other time, status writes included, it holds its value.
- R7: The arbitration flag (bit 3) sets after `ev_arb_lost` with `arb_kind` 0 (high data bit), 1 (NACK bit) or 2 (START or repeated START). Code 3 does not set it. `addr_wr` clears it.
- R8: The bus-error flag (bit 2) sets after `ev_bus_err`. It clears on a status write with data bit 2 at one, or on `addr_wr`.
- R9: `status` packs the flags as bit 7 receive, 6 send, 5 clock hold, 4 acknowledge, 3 arbitration, 2 bus error, and bits 1:0 = `bus_state`. After reset, bits 7:2 are zero.
- R10: `irq` = (receive flag AND `rif_en`) OR (send flag AND `wif_en`), with no added delay.
- R11: When a set event and a clearing access for the same flag land in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_rx_byte | input | 1 | Byte received in master read |
| rx_byte_faulted | input | 1 | Arbitration loss or bus error occurred during that byte |
| ev_tx_byte | input | 1 | Byte sent in master write |
| ev_arb_lost | input | 1 | Arbitration lost |
| arb_kind | input | 2 | Kind of bit being driven when arbitration was lost: 0 data high, 1 NACK, 2 START, 3 other |
| ev_bus_err | input | 1 | Bus error detected |
| ev_start_unknown | input | 1 | START requested while the bus state was unknown |
| rx_ack_valid | input | 1 | A new acknowledge sample is on `rx_ack_bit` |
| rx_ack_bit | input | 1 | Sampled acknowledge, 1 = NACK |
| st_wr | input | 1 | Status register write strobe |
| st_wdata | input | 8 | Status write data |
| addr_wr | input | 1 | Address register write |
| data_wr | input | 1 | Data register write |
| data_rd | input | 1 | Data register read |
| cmd_wr | input | 1 | Command field write |
| cmd_code | input | 2 | Command written, 0 = no command |
| bus_state | input | 2 | Bus state from the tracker, reported in bits 1:0 |
| rif_en | input | 1 | Receive interrupt enable |
| wif_en | input | 1 | Send interrupt enable |
| status | output | 8 | Packed status byte |
| rif | output | 1 | Receive flag |
| wif | output | 1 | Send flag |
| clkhold | output | 1 | Clock held low |
| rxack | output | 1 | Last acknowledge bit |
| arblost | output | 1 | Arbitration-lost flag |
| buserr | output | 1 | Bus-error flag |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The hardest case is collision: a set event in the same cycle as one or more clearing accesses on the same flag, with the other flag in some unrelated state. Random stimulus rarely lines this up for all four sticky flags. Directed steps therefore fire every set source together with address writes, data reads, valid commands and write-one-to-clear masks. They also cover the near misses: a faulted receive, arbitration code 3, a zero command code, and a zero status write. Around these, seeded random cycles at low event rates let the flags build up and be cleared in mixed orders.

// File: rtl/twm_status_pkg.sv
package twm_status_pkg;
  localparam int STAT_W   = 8;
  localparam int BSTATE_W = 2;
  localparam int CMD_W    = 2;
  localparam int NFLAG    = 4;

  localparam int POS_RIF  = 7;
  localparam int POS_WIF  = 6;
  localparam int POS_HOLD = 5;
  localparam int POS_ACK  = 4;
  localparam int POS_ARB  = 3;
  localparam int POS_BERR = 2;

  localparam int IX_RIF  = 0;
  localparam int IX_WIF  = 1;
  localparam int IX_ARB  = 2;
  localparam int IX_BERR = 3;

  typedef enum logic [1:0] {
    ARB_DATA_HIGH = 2'd0,
    ARB_NACK_BIT  = 2'd1,
    ARB_START     = 2'd2,
    ARB_OTHER     = 2'd3
  } arb_kind_t;

  function automatic logic arb_counts(input logic [1:0] kind);
    return kind != ARB_OTHER;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(
    input logic r, input logic w, input logic a, input logic arb,
    input logic be, input logic [BSTATE_W-1:0] bs);
    logic [STAT_W-1:0] s;
    s = '0;
    s[POS_RIF]  = r;
    s[POS_WIF]  = w;
    s[POS_HOLD] = r | w;
    s[POS_ACK]  = a;
    s[POS_ARB]  = arb;
    s[POS_BERR] = be;
    s[BSTATE_W-1:0] = bs;
    return s;
  endfunction
endpackage

// File: rtl/twm_event_decode.sv
module twm_event_decode
  import twm_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rx_byte,
  input  logic              rx_byte_faulted,
  input  logic              ev_tx_byte,
  input  logic              ev_arb_lost,
  input  logic [1:0]        arb_kind,
  input  logic              ev_bus_err,
  input  logic              ev_start_unknown,
  input  logic              st_wr,
  input  logic [STAT_W-1:0] st_wdata,
  input  logic              addr_wr,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_code,
  output logic [NFLAG-1:0]  set_vec,
  output logic [NFLAG-1:0]  clr_vec,
  output logic              side_clr
);
  logic nack_arb;
  logic cmd_valid;
  logic [NFLAG-1:0] w1c;

  always_comb begin
    nack_arb  = ev_arb_lost && (arb_kind == ARB_NACK_BIT);
    cmd_valid = cmd_wr && (cmd_code != '0);
    side_clr  = addr_wr | data_wr | data_rd | cmd_valid;

    set_vec[IX_RIF]  = ev_rx_byte && !rx_byte_faulted;
    set_vec[IX_WIF]  = ev_tx_byte | nack_arb | ev_start_unknown;
    set_vec[IX_ARB]  = ev_arb_lost && arb_counts(arb_kind);
    set_vec[IX_BERR] = ev_bus_err;

    w1c[IX_RIF]  = st_wr && st_wdata[POS_RIF];
    w1c[IX_WIF]  = st_wr && st_wdata[POS_WIF];
    w1c[IX_ARB]  = st_wr && st_wdata[POS_ARB];
    w1c[IX_BERR] = st_wr && st_wdata[POS_BERR];

    clr_vec[IX_RIF]  = w1c[IX_RIF]  | side_clr;
    clr_vec[IX_WIF]  = w1c[IX_WIF]  | side_clr;
    clr_vec[IX_ARB]  = w1c[IX_ARB]  | addr_wr;
    clr_vec[IX_BERR] = w1c[IX_BERR] | addr_wr;
  end

  // a faulted received byte never requests the receive flag
  p_rx_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_byte && rx_byte_faulted) |-> !set_vec[IX_RIF]);
  // arbitration code 3 never requests the arbitration flag
  p_arb_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_kind == ARB_OTHER) |-> !set_vec[IX_ARB]);
  // a zero command code is not a side clear
  p_cmd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_code == '0 && !addr_wr && !data_wr && !data_rd) |-> !side_clr);
endmodule

// File: rtl/twm_flag_cell.sv
module twm_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q);
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q));
endmodule

// File: rtl/twm_ack_capture.sv
module twm_ack_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_ack_valid,
  input  logic rx_ack_bit,
  output logic ack_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)            ack_q <= 1'b0;
    else if (rx_ack_valid) ack_q <= rx_ack_bit;
  end

  p_ack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ack_valid |=> $stable(ack_q));
  p_ack_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack_valid |=> (ack_q == $past(rx_ack_bit)));
endmodule

// File: rtl/twm_status_ctrl.sv
module twm_status_ctrl
  import twm_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rx_byte,
  input  logic              rx_byte_faulted,
  input  logic              ev_tx_byte,
  input  logic              ev_arb_lost,
  input  logic [1:0]        arb_kind,
  input  logic              ev_bus_err,
  input  logic              ev_start_unknown,
  input  logic              rx_ack_valid,
  input  logic              rx_ack_bit,
  input  logic              st_wr,
  input  logic [STAT_W-1:0] st_wdata,
  input  logic              addr_wr,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic [BSTATE_W-1:0] bus_state,
  input  logic              rif_en,
  input  logic              wif_en,
  output logic [STAT_W-1:0] status,
  output logic              rif,
  output logic              wif,
  output logic              clkhold,
  output logic              rxack,
  output logic              arblost,
  output logic              buserr,
  output logic              irq,
  output logic              scl_hold
);
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] clr_vec;
  logic [NFLAG-1:0] flag_q;
  logic             side_clr;

  twm_event_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_byte(ev_rx_byte), .rx_byte_faulted(rx_byte_faulted),
    .ev_tx_byte(ev_tx_byte), .ev_arb_lost(ev_arb_lost), .arb_kind(arb_kind),
    .ev_bus_err(ev_bus_err), .ev_start_unknown(ev_start_unknown),
    .st_wr(st_wr), .st_wdata(st_wdata), .addr_wr(addr_wr),
    .data_wr(data_wr), .data_rd(data_rd), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .set_vec(set_vec), .clr_vec(clr_vec), .side_clr(side_clr)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    twm_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_vec[g]), .clr_i(clr_vec[g]), .q(flag_q[g])
    );
  end

  twm_ack_capture u_ack (
    .clk(clk), .rst_n(rst_n),
    .rx_ack_valid(rx_ack_valid), .rx_ack_bit(rx_ack_bit), .ack_q(rxack)
  );

  always_comb begin
    rif      = flag_q[IX_RIF];
    wif      = flag_q[IX_WIF];
    arblost  = flag_q[IX_ARB];
    buserr   = flag_q[IX_BERR];
    clkhold  = rif | wif;
    scl_hold = clkhold;
    irq      = (rif & rif_en) | (wif & wif_en);
    status   = pack_status(rif, wif, rxack, arblost, buserr, bus_state);
  end

  p_rif_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_byte && !rx_byte_faulted) |=> rif);
  p_wif_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_byte || ev_start_unknown) |=> wif);
  p_side_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (side_clr && !set_vec[IX_WIF]) |=> !wif);
  p_hold_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && !side_clr && !st_wr) |=> scl_hold);
  p_arb_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !ev_arb_lost) |=> !arblost);
  p_berr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |=> buserr);
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_byte && !rx_byte_faulted && side_clr) |=> rif);
endmodule

// File: tb/twm_status_ctrl_test.sv
module twm_status_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_rx_byte, rx_byte_faulted, ev_tx_byte, ev_arb_lost, ev_bus_err;
  logic ev_start_unknown, rx_ack_valid, rx_ack_bit, st_wr, addr_wr, data_wr;
  logic data_rd, cmd_wr, rif_en, wif_en;
  logic [1:0] arb_kind, cmd_code, bus_state;
  logic [7:0] st_wdata;
  logic [7:0] status;
  logic rif, wif, clkhold, rxack, arblost, buserr, irq, scl_hold;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic m_rif, m_wif, m_ack, m_arb, m_berr;

  always #5 clk = ~clk;

  twm_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ev_rx_byte(ev_rx_byte), .rx_byte_faulted(rx_byte_faulted),
    .ev_tx_byte(ev_tx_byte), .ev_arb_lost(ev_arb_lost), .arb_kind(arb_kind),
    .ev_bus_err(ev_bus_err), .ev_start_unknown(ev_start_unknown),
    .rx_ack_valid(rx_ack_valid), .rx_ack_bit(rx_ack_bit), .st_wr(st_wr),
    .st_wdata(st_wdata), .addr_wr(addr_wr), .data_wr(data_wr), .data_rd(data_rd),
    .cmd_wr(cmd_wr), .cmd_code(cmd_code), .bus_state(bus_state), .rif_en(rif_en),
    .wif_en(wif_en), .status(status), .rif(rif), .wif(wif), .clkhold(clkhold),
    .rxack(rxack), .arblost(arblost), .buserr(buserr), .irq(irq), .scl_hold(scl_hold)
  );

  function automatic logic [7:0] exp_status();
    return {m_rif, m_wif, m_rif | m_wif, m_ack, m_arb, m_berr, bus_state};
  endfunction

  function automatic logic exp_irq();
    return (m_rif && rif_en) || (m_wif && wif_en);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_rx_byte = 0; rx_byte_faulted = 0; ev_tx_byte = 0; ev_arb_lost = 0;
    arb_kind = 0; ev_bus_err = 0; ev_start_unknown = 0; rx_ack_valid = 0;
    rx_ack_bit = 0; st_wr = 0; st_wdata = 0; addr_wr = 0; data_wr = 0;
    data_rd = 0; cmd_wr = 0; cmd_code = 0;
  endtask

  // next model state, written from the requirements
  task automatic model_update();
    logic side, rs, ws, as, bs;
    side = addr_wr || data_wr || data_rd || (cmd_wr && cmd_code != 0);
    rs = ev_rx_byte && !rx_byte_faulted;
    ws = ev_tx_byte || ev_start_unknown || (ev_arb_lost && arb_kind == 2'd1);
    as = ev_arb_lost && arb_kind != 2'd3;
    bs = ev_bus_err;
    if (rs) m_rif = 1; else if (side || (st_wr && st_wdata[7])) m_rif = 0;
    if (ws) m_wif = 1; else if (side || (st_wr && st_wdata[6])) m_wif = 0;
    if (as) m_arb = 1; else if (addr_wr || (st_wr && st_wdata[3])) m_arb = 0;
    if (bs) m_berr = 1; else if (addr_wr || (st_wr && st_wdata[2])) m_berr = 0;
    if (rx_ack_valid) m_ack = rx_ack_bit;
  endtask

  task automatic compare_all(input string tag);
    check({tag, " R9 status"}, status, exp_status());
    check({tag, " R1 rif"}, {7'd0, rif}, {7'd0, m_rif});
    check({tag, " R2 wif"}, {7'd0, wif}, {7'd0, m_wif});
    check({tag, " R5 scl_hold"}, {6'd0, scl_hold, clkhold}, {6'd0, {2{m_rif | m_wif}}});
    check({tag, " R6 rxack"}, {7'd0, rxack}, {7'd0, m_ack});
    check({tag, " R7 arblost"}, {7'd0, arblost}, {7'd0, m_arb});
    check({tag, " R8 buserr"}, {7'd0, buserr}, {7'd0, m_berr});
    check({tag, " R10 irq"}, {7'd0, irq}, {7'd0, exp_irq()});
  endtask

  task automatic tick(input string tag);
    model_update();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    compare_all(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    seed = 1234;
    void'($urandom(seed));
    idle_inputs();
    bus_state = 2'd1; rif_en = 1; wif_en = 0;
    m_rif = 0; m_wif = 0; m_ack = 0; m_arb = 0; m_berr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare_all("reset R9");

    // R1 clean and faulted receive
    ev_rx_byte = 1; rx_byte_faulted = 1; tick("R1 faulted rx");
    ev_rx_byte = 1; tick("R1 clean rx");
    // R3 zero write no effect, then w1c
    st_wr = 1; st_wdata = 8'h00; tick("R3 zero write");
    st_wr = 1; st_wdata = 8'h80; tick("R3 w1c rif");
    // R2 sources
    ev_tx_byte = 1; ev_bus_err = 1; tick("R2 tx with fault");
    wif_en = 1; data_rd = 1; tick("R4 data read");
    ev_arb_lost = 1; arb_kind = 2'd1; tick("R2 R7 nack arb");
    cmd_wr = 1; cmd_code = 2'd0; tick("R4 cmd zero");
    cmd_wr = 1; cmd_code = 2'd2; tick("R4 cmd valid");
    ev_start_unknown = 1; tick("R2 start unknown");
    data_wr = 1; tick("R4 data write");
    ev_arb_lost = 1; arb_kind = 2'd3; tick("R7 code 3");
    ev_arb_lost = 1; arb_kind = 2'd2; tick("R7 start arb");
    st_wr = 1; st_wdata = 8'h08; tick("R3 w1c arb");
    ev_arb_lost = 1; arb_kind = 2'd0; tick("R7 data arb");
    addr_wr = 1; tick("R7 R8 addr clear");
    ev_bus_err = 1; tick("R8 set");
    st_wr = 1; st_wdata = 8'h04; tick("R8 w1c");
    // R6 ack
    rx_ack_valid = 1; rx_ack_bit = 1; tick("R6 nack");
    st_wr = 1; st_wdata = 8'h10; tick("R6 status write ignored");
    rx_ack_valid = 1; rx_ack_bit = 0; tick("R6 ack");
    // R11 collisions
    ev_rx_byte = 1; addr_wr = 1; tick("R11 rif vs addr");
    ev_tx_byte = 1; st_wr = 1; st_wdata = 8'hFF; data_rd = 1; tick("R11 wif vs w1c");
    ev_arb_lost = 1; arb_kind = 2'd0; addr_wr = 1; tick("R11 arb vs addr");
    ev_bus_err = 1; st_wr = 1; st_wdata = 8'h04; addr_wr = 1; tick("R11 berr vs clr");
    bus_state = 2'd2; rif_en = 0; tick("R9 R10 idle");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      ev_rx_byte       = ($urandom % 8) == 0;
      rx_byte_faulted  = ($urandom % 3) == 0;
      ev_tx_byte       = ($urandom % 8) == 0;
      ev_arb_lost      = ($urandom % 10) == 0;
      arb_kind         = 2'($urandom);
      ev_bus_err       = ($urandom % 12) == 0;
      ev_start_unknown = ($urandom % 16) == 0;
      rx_ack_valid     = ($urandom % 4) == 0;
      rx_ack_bit       = 1'($urandom);
      st_wr            = ($urandom % 6) == 0;
      st_wdata         = 8'($urandom);
      addr_wr          = ($urandom % 14) == 0;
      data_wr          = ($urandom % 14) == 0;
      data_rd          = ($urandom % 14) == 0;
      cmd_wr           = ($urandom % 10) == 0;
      cmd_code         = 2'($urandom);
      if (($urandom % 20) == 0) bus_state = 2'($urandom);
      if (($urandom % 25) == 0) rif_en = 1'($urandom);
      if (($urandom % 25) == 0) wif_en = 1'($urandom);
      tick("random R11");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule